// File: doc/BRIEF.md
# Bus Access Abort Monitor

This block watches every access on a 32-bit processor memory bus before memory acts on it. An access can be an instruction fetch, a data read, a data write or a swap. If its address falls inside a configured half-open address window, the block records an abort for it. The abort is a prefetch abort for a fetch and a data abort for any other operation. A write that aborts never reaches memory. While an abort is pending, the response data returned to the processor is replaced by a fixed abort word.

The block also does three other jobs:
- It decodes a console address. A byte or halfword store to that address is taken out of the memory path. It then either emits a character strobe or, for one special value, raises a sticky halt output.
- It sets a sticky flag when the exception vector word is written.
- It counts bus cycles by type: sequential, non-sequential, internal and coprocessor.

The memory array and the host side of the console are outside this block. The block only drives the memory write enable and passes through the read data.

Top module: `bus_abort_monitor`

## Requirements
- R1: An access aborts when LO_ADDR <= address < HI_ADDR, with defaults of 8 MiB (0x0080_0000) and 26 MiB (0x01A0_0000). The abort appears on the outputs in the cycle after the access strobe. The address HI_ADDR itself does not abort.
- R2: An aborting fetch (acc_op=0) raises abort_pf. An aborting read (1), write (2) or swap (3) raises abort_dt. The two outputs are never high together. An aborting write or swap keeps mem_wr_en low.
- R3: A pending abort is held while no access occurs. It is cleared by the next access outside the window.
- R4: While an abort is pending, resp_data equals the ABORT_WORD parameter (default 0xDEAD_C0DE). Otherwise resp_data equals mem_rdata.
- R5: A console store is a write (acc_op=2) of byte (acc_size=0) or halfword (acc_size=1) size to TUBE_ADDR (default 0x0300_0000). It keeps mem_wr_en low. The stored value is the low byte for a byte store and the low 16 bits for a halfword store. If that value equals 4, halt is set and stays set until reset. Any other value raises con_valid for one cycle, with the low byte on con_char. A word store to TUBE_ADDR writes memory normally.
- R6: A non-aborting word-sized (acc_size=2) write or swap to VEC_ADDR (default 0x8) sets vec_installed, which stays set until reset. A byte write to the same address does not set it.
- R7: A word access (fetch, read or write) with acc_seq=1 adds one to cnt_s.
- R8: A word fetch, read or write with acc_seq=0, and every byte or halfword fetch, read or write, adds one to cnt_n.
- R9: A swap of any size adds two to cnt_n and nothing to cnt_s.
- R10: icyc_valid adds icyc_num to cnt_i, and ccyc_valid adds ccyc_num to cnt_c. Either one, in a cycle with no access, clears a pending abort.
- R11: A synchronous reset clears all counters, flags, console outputs and the pending abort. Counters wrap on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Bus access strobe |
| acc_op | input | 2 | 0 fetch, 1 read, 2 write, 3 swap |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_seq | input | 1 | Sequential cycle |
| acc_addr | input | 32 | Access address |
| acc_wdata | input | 32 | Store data |
| mem_rdata | input | 32 | Data read from memory |
| icyc_valid | input | 1 | Internal cycles reported |
| icyc_num | input | 8 | Number of internal cycles |
| ccyc_valid | input | 1 | Coprocessor cycles reported |
| ccyc_num | input | 8 | Number of coprocessor cycles |
| mem_wr_en | output | 1 | Memory write enable for this access |
| resp_data | output | 32 | Read data returned to the processor |
| abort_pf | output | 1 | Prefetch abort pending |
| abort_dt | output | 1 | Data abort pending |
| con_valid | output | 1 | Console character strobe |
| con_char | output | 8 | Console character |
| halt | output | 1 | Halt request, sticky |
| vec_installed | output | 1 | Vector word written, sticky |
| cnt_s | output | 32 | Sequential cycle count |
| cnt_n | output | 32 | Non-sequential cycle count |
| cnt_i | output | 32 | Internal cycle count |
| cnt_c | output | 32 | Coprocessor cycle count |

## Verification
A wrong pending-abort state shows at the ports one cycle after the access that caused it. It appears on abort_pf or abort_dt, and at the same moment resp_data is substituted, or not substituted, with the abort word. A wrong counter decision shows in the counter output one cycle after the access. Because each counter accumulates, the error then persists in every later comparison. Window boundaries, console values and vector address sizes are each probed on both sides of their edges, so an off-by-one comparison changes the very next cycle's outputs.

// File: rtl/bam_pkg.sv
package bam_pkg;
    typedef enum logic [1:0] {
        OP_FETCH = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_SWAP  = 2'd3
    } bam_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } bam_size_e;
endpackage

// File: rtl/bam_window.sv
module bam_window #(
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] LO_ADDR = 32'h0080_0000,
    parameter logic [31:0] HI_ADDR = 32'h01A0_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LO_W = LO_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] HI_W = HI_ADDR[ADDR_W-1:0];

    // half-open: the upper bound is excluded
    always_comb begin
        hit = (addr >= LO_W) && (addr < HI_W);
    end
endmodule

// File: rtl/bam_tube.sv
module bam_tube
    import bam_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] TUBE_ADDR = 32'h0300_0000,
    parameter int          STOP_CODE = 4
) (
    input  logic              valid,
    input  logic [1:0]        op,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              blocked,
    output logic              take,
    output logic              stop_req,
    output logic [7:0]        ch
);
    localparam logic [ADDR_W-1:0] TUBE_W = TUBE_ADDR[ADDR_W-1:0];

    logic        narrow;
    logic [15:0] value;

    always_comb begin
        narrow = (size == SZ_BYTE) || (size == SZ_HALF);
        take   = valid && !blocked && (op == OP_WRITE) && narrow && (addr == TUBE_W);
        value  = (size == SZ_BYTE) ? {8'd0, wdata[7:0]} : wdata[15:0];
        stop_req = take && (value == 16'(STOP_CODE));
        ch     = wdata[7:0];
    end
endmodule

// File: rtl/bam_tally.sv
module bam_tally
    import bam_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] op,
    input  logic [1:0] size,
    input  logic       seq,
    output logic       s_inc,
    output logic [1:0] n_inc
);
    logic is_word;

    always_comb begin
        is_word = (size == SZ_WORD);
        s_inc   = 1'b0;
        n_inc   = 2'd0;
        if (valid) begin
            if (op == OP_SWAP) begin
                n_inc = 2'd2;
            end else if (is_word && seq) begin
                s_inc = 1'b1;
            end else begin
                n_inc = 2'd1;
            end
        end
    end
endmodule

// File: rtl/bus_abort_monitor.sv
module bus_abort_monitor
    import bam_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          CNT_W      = 32,
    parameter int          NUM_W      = 8,
    parameter logic [31:0] LO_ADDR    = 32'h0080_0000,
    parameter logic [31:0] HI_ADDR    = 32'h01A0_0000,
    parameter logic [31:0] TUBE_ADDR  = 32'h0300_0000,
    parameter logic [31:0] VEC_ADDR   = 32'h0000_0008,
    parameter logic [31:0] ABORT_WORD = 32'hDEAD_C0DE,
    parameter int          STOP_CODE  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [1:0]        acc_op,
    input  logic [1:0]        acc_size,
    input  logic              acc_seq,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              icyc_valid,
    input  logic [NUM_W-1:0]  icyc_num,
    input  logic              ccyc_valid,
    input  logic [NUM_W-1:0]  ccyc_num,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] resp_data,
    output logic              abort_pf,
    output logic              abort_dt,
    output logic              con_valid,
    output logic [7:0]        con_char,
    output logic              halt,
    output logic              vec_installed,
    output logic [CNT_W-1:0]  cnt_s,
    output logic [CNT_W-1:0]  cnt_n,
    output logic [CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]  cnt_c
);
    localparam logic [ADDR_W-1:0] VEC_W   = VEC_ADDR[ADDR_W-1:0];
    localparam logic [DATA_W-1:0] ABORT_D = ABORT_WORD[DATA_W-1:0];

    typedef struct packed {
        logic             pend;
        logic             pf;
        logic             con_valid;
        logic [7:0]       con_char;
        logic             halt;
        logic             vec;
        logic [CNT_W-1:0] s;
        logic [CNT_W-1:0] n;
        logic [CNT_W-1:0] i;
        logic [CNT_W-1:0] c;
    } bam_state_t;

    bam_state_t st_d, st_q;

    logic       win_hit;
    logic       tube_take;
    logic       tube_stop;
    logic [7:0] tube_ch;
    logic       s_inc;
    logic [1:0] n_inc;
    logic       is_store;

    bam_window #(
        .ADDR_W (ADDR_W),
        .LO_ADDR(LO_ADDR),
        .HI_ADDR(HI_ADDR)
    ) u_window (
        .addr(acc_addr),
        .hit (win_hit)
    );

    bam_tube #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TUBE_ADDR(TUBE_ADDR),
        .STOP_CODE(STOP_CODE)
    ) u_tube (
        .valid   (acc_valid),
        .op      (acc_op),
        .size    (acc_size),
        .addr    (acc_addr),
        .wdata   (acc_wdata),
        .blocked (win_hit),
        .take    (tube_take),
        .stop_req(tube_stop),
        .ch      (tube_ch)
    );

    bam_tally u_tally (
        .valid(acc_valid),
        .op   (acc_op),
        .size (acc_size),
        .seq  (acc_seq),
        .s_inc(s_inc),
        .n_inc(n_inc)
    );

    always_comb begin
        is_store  = (acc_op == OP_WRITE) || (acc_op == OP_SWAP);
        mem_wr_en = acc_valid && is_store && !win_hit && !tube_take;

        st_d           = st_q;
        st_d.con_valid = 1'b0;

        if (acc_valid) begin
            if (win_hit) begin
                st_d.pend = 1'b1;
                st_d.pf   = (acc_op == OP_FETCH);
            end else begin
                st_d.pend = 1'b0;
            end
        end else if (icyc_valid || ccyc_valid) begin
            st_d.pend = 1'b0;
        end

        if (tube_take) begin
            if (tube_stop) begin
                st_d.halt = 1'b1;
            end else begin
                st_d.con_valid = 1'b1;
                st_d.con_char  = tube_ch;
            end
        end

        if (acc_valid && !win_hit && is_store && (acc_size == SZ_WORD) && (acc_addr == VEC_W)) begin
            st_d.vec = 1'b1;
        end

        st_d.s = st_q.s + CNT_W'(s_inc);
        st_d.n = st_q.n + CNT_W'(n_inc);
        st_d.i = st_q.i + (icyc_valid ? CNT_W'(icyc_num) : '0);
        st_d.c = st_q.c + (ccyc_valid ? CNT_W'(ccyc_num) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign abort_pf      = st_q.pend && st_q.pf;
    assign abort_dt      = st_q.pend && !st_q.pf;
    assign resp_data     = st_q.pend ? ABORT_D : mem_rdata;
    assign con_valid     = st_q.con_valid;
    assign con_char      = st_q.con_char;
    assign halt          = st_q.halt;
    assign vec_installed = st_q.vec;
    assign cnt_s         = st_q.s;
    assign cnt_n         = st_q.n;
    assign cnt_i         = st_q.i;
    assign cnt_c         = st_q.c;
endmodule

// File: rtl/bus_abort_monitor_chk.sv
module bus_abort_monitor_chk #(
    parameter int          CNT_W      = 32,
    parameter logic [31:0] LO_ADDR    = 32'h0080_0000,
    parameter logic [31:0] HI_ADDR    = 32'h01A0_0000,
    parameter logic [31:0] ABORT_WORD = 32'hDEAD_C0DE
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic [1:0]       acc_op,
    input logic [1:0]       acc_size,
    input logic             acc_seq,
    input logic [31:0]      acc_addr,
    input logic             mem_wr_en,
    input logic [31:0]      resp_data,
    input logic             abort_pf,
    input logic             abort_dt,
    input logic             halt,
    input logic             vec_installed,
    input logic [CNT_W-1:0] cnt_s
);
    logic in_win;
    assign in_win = (acc_addr >= LO_ADDR) && (acc_addr < HI_ADDR);

    // R1
    fetch_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_op == 2'd0 && in_win) |=> abort_pf);

    // R2
    abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(abort_pf && abort_dt));

    // R2
    abort_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && in_win) |-> !mem_wr_en);

    // R4
    abort_word_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_pf || abort_dt) |-> (resp_data == ABORT_WORD));

    // R5
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    // R6
    vec_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        vec_installed |=> vec_installed);

    // R7
    seq_count_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_seq && acc_size == 2'd2 && acc_op != 2'd3)
            |=> (cnt_s == $past(cnt_s) + 1'b1));
endmodule

bind bus_abort_monitor bus_abort_monitor_chk #(
    .CNT_W     (CNT_W),
    .LO_ADDR   (LO_ADDR),
    .HI_ADDR   (HI_ADDR),
    .ABORT_WORD(ABORT_WORD)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_op       (acc_op),
    .acc_size     (acc_size),
    .acc_seq      (acc_seq),
    .acc_addr     (acc_addr),
    .mem_wr_en    (mem_wr_en),
    .resp_data    (resp_data),
    .abort_pf     (abort_pf),
    .abort_dt     (abort_dt),
    .halt         (halt),
    .vec_installed(vec_installed),
    .cnt_s        (cnt_s)
);

// File: tb/bus_abort_monitor_test.sv
module bus_abort_monitor_test;
    localparam logic [31:0] LO   = 32'h0080_0000;
    localparam logic [31:0] HI   = 32'h01A0_0000;
    localparam logic [31:0] TUBE = 32'h0300_0000;
    localparam logic [31:0] AW   = 32'hDEAD_C0DE;
    localparam logic [31:0] RD   = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_op = 2'd0;
    logic [1:0]  acc_size = 2'd2;
    logic        acc_seq = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] mem_rdata = RD;
    logic        icyc_valid = 1'b0;
    logic [7:0]  icyc_num = '0;
    logic        ccyc_valid = 1'b0;
    logic [7:0]  ccyc_num = '0;
    logic        mem_wr_en;
    logic [31:0] resp_data;
    logic        abort_pf, abort_dt, con_valid, halt, vec_installed;
    logic [7:0]  con_char;
    logic [31:0] cnt_s, cnt_n, cnt_i, cnt_c;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic wr_seen;
    logic [31:0] exp_s = 0, exp_n = 0, exp_i = 0, exp_c = 0;

    bus_abort_monitor uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_op(acc_op),
        .acc_size(acc_size), .acc_seq(acc_seq), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .mem_rdata(mem_rdata), .icyc_valid(icyc_valid),
        .icyc_num(icyc_num), .ccyc_valid(ccyc_valid), .ccyc_num(ccyc_num),
        .mem_wr_en(mem_wr_en), .resp_data(resp_data), .abort_pf(abort_pf),
        .abort_dt(abort_dt), .con_valid(con_valid), .con_char(con_char),
        .halt(halt), .vec_installed(vec_installed), .cnt_s(cnt_s),
        .cnt_n(cnt_n), .cnt_i(cnt_i), .cnt_c(cnt_c)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one access; registered results are visible on return
    task automatic acc(input logic [1:0] op, input logic [1:0] sz, input logic seq,
                       input logic [31:0] addr, input logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_op = op; acc_size = sz; acc_seq = seq;
        acc_addr = addr; acc_wdata = wd;
        #2 wr_seen = mem_wr_en;
        @(posedge clk); #1;
        acc_valid = 1'b0;
        if (op == 2'd3) exp_n += 2;
        else if (sz == 2'd2 && seq) exp_s += 1;
        else exp_n += 1;
    endtask

    task automatic idle_cycle();
        @(negedge clk); @(posedge clk); #1;
    endtask

    task automatic t_reset();
        check("R11", "cnt_s", cnt_s, 0);
        check("R11", "cnt_n", cnt_n, 0);
        check("R11", "abort", {30'd0, abort_pf, abort_dt}, 0);
        check("R11", "flags", {29'd0, halt, vec_installed, con_valid}, 0);
        check("R4", "resp passthrough", resp_data, RD);
    endtask

    task automatic t_window();
        acc(2'd1, 2'd2, 1'b0, LO - 4, 0);
        check("R1", "below lo", {31'd0, abort_dt}, 0);
        acc(2'd1, 2'd2, 1'b0, LO, 0);
        check("R1", "at lo", {31'd0, abort_dt}, 1);
        check("R4", "abort word", resp_data, AW);
        acc(2'd1, 2'd2, 1'b0, HI - 4, 0);
        check("R1", "hi-4", {31'd0, abort_dt}, 1);
        acc(2'd1, 2'd2, 1'b0, HI, 0);
        check("R1", "at hi", {31'd0, abort_dt}, 0);
        check("R3", "cleared by outside", {30'd0, abort_pf, abort_dt}, 0);
    endtask

    task automatic t_kinds();
        acc(2'd0, 2'd2, 1'b1, LO + 32'h100, 0);
        check("R2", "fetch pf/dt", {30'd0, abort_pf, abort_dt}, 2'b10);
        idle_cycle();
        check("R3", "held idle", {31'd0, abort_pf}, 1);
        acc(2'd2, 2'd2, 1'b0, LO + 32'h200, 32'h55);
        check("R2", "write wr_en", {31'd0, wr_seen}, 0);
        check("R2", "write pf/dt", {30'd0, abort_pf, abort_dt}, 2'b01);
        acc(2'd3, 2'd2, 1'b0, LO + 32'h300, 32'h66);
        check("R2", "swap wr_en", {31'd0, wr_seen}, 0);
        acc(2'd2, 2'd2, 1'b0, 32'h100, 32'h77);
        check("R2", "outside write wr_en", {31'd0, wr_seen}, 1);
        check("R3", "cleared", {31'd0, abort_dt}, 0);
        check("R4", "resp passthrough", resp_data, RD);
    endtask

    task automatic t_tube();
        acc(2'd2, 2'd0, 1'b0, TUBE, 32'h0000_0141);
        check("R5", "byte wr_en", {31'd0, wr_seen}, 0);
        check("R5", "con_valid", {31'd0, con_valid}, 1);
        check("R5", "con_char", {24'd0, con_char}, 32'h41);
        idle_cycle();
        check("R5", "con_valid one cycle", {31'd0, con_valid}, 0);
        acc(2'd2, 2'd1, 1'b0, TUBE, 32'h0000_0104);
        check("R5", "half 0x104 not halt", {31'd0, halt}, 0);
        check("R5", "half char", {31'd0, con_valid}, 1);
        acc(2'd2, 2'd2, 1'b0, TUBE, 32'h4);
        check("R5", "word store passes", {31'd0, wr_seen}, 1);
        check("R5", "word no halt", {31'd0, halt}, 0);
        acc(2'd2, 2'd0, 1'b0, TUBE, 32'h0000_0304);
        check("R5", "halt set", {31'd0, halt}, 1);
        check("R5", "no char on halt", {31'd0, con_valid}, 0);
        idle_cycle();
        check("R5", "halt sticky", {31'd0, halt}, 1);
    endtask

    task automatic t_vector();
        acc(2'd2, 2'd0, 1'b0, 32'h8, 32'h1);
        check("R6", "byte no vec", {31'd0, vec_installed}, 0);
        acc(2'd2, 2'd2, 1'b0, 32'hC, 32'h1);
        check("R6", "other addr no vec", {31'd0, vec_installed}, 0);
        acc(2'd2, 2'd2, 1'b0, 32'h8, 32'h1);
        check("R6", "word vec", {31'd0, vec_installed}, 1);
        acc(2'd1, 2'd2, 1'b0, 32'h0, 0);
        check("R6", "vec sticky", {31'd0, vec_installed}, 1);
    endtask

    task automatic t_counts();
        logic [31:0] s0, n0;
        s0 = cnt_s; n0 = cnt_n;
        acc(2'd0, 2'd2, 1'b1, 32'h40, 0);
        acc(2'd1, 2'd2, 1'b1, 32'h44, 0);
        check("R7", "seq word", cnt_s, s0 + 2);
        check("R7", "seq word n unchanged", cnt_n, n0);
        acc(2'd1, 2'd0, 1'b1, 32'h48, 0);
        check("R8", "seq byte counts n", cnt_n, n0 + 1);
        acc(2'd2, 2'd1, 1'b0, 32'h4C, 0);
        acc(2'd1, 2'd2, 1'b0, 32'h50, 0);
        check("R8", "n total", cnt_n, n0 + 3);
        acc(2'd3, 2'd2, 1'b1, 32'h54, 0);
        check("R9", "word swap", cnt_n, n0 + 5);
        acc(2'd3, 2'd0, 1'b0, 32'h58, 0);
        check("R9", "byte swap", cnt_n, n0 + 7);
        check("R9", "swap no s", cnt_s, s0 + 2);
        check("R7", "model s", cnt_s, exp_s);
        check("R8", "model n", cnt_n, exp_n);
    endtask

    task automatic t_icyc();
        acc(2'd1, 2'd2, 1'b0, LO, 0);
        check("R10", "abort before", {31'd0, abort_dt}, 1);
        @(negedge clk);
        icyc_valid = 1'b1; icyc_num = 8'd200;
        @(posedge clk); #1;
        icyc_valid = 1'b0; exp_i += 200;
        check("R10", "cnt_i", cnt_i, exp_i);
        check("R10", "icyc clears abort", {31'd0, abort_dt}, 0);
        acc(2'd0, 2'd2, 1'b0, LO, 0);
        @(negedge clk);
        ccyc_valid = 1'b1; ccyc_num = 8'd255;
        @(posedge clk); #1;
        @(negedge clk);
        ccyc_num = 8'd3;
        @(posedge clk); #1;
        ccyc_valid = 1'b0; exp_c += 258;
        check("R10", "cnt_c", cnt_c, exp_c);
        check("R10", "ccyc clears abort", {31'd0, abort_pf}, 0);
    endtask

    task automatic t_rst_again();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        check("R11", "cnt_i cleared", cnt_i, 0);
        check("R11", "cnt_c cleared", cnt_c, 0);
        check("R11", "halt cleared", {31'd0, halt}, 0);
        check("R11", "vec cleared", {31'd0, vec_installed}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_window();
        t_kinds();
        t_tube();
        t_vector();
        t_counts();
        t_icyc();
        t_rst_again();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule